// File: doc/BRIEF.md
# Descriptor Ring Transmit Engine

This block is the send half of a bus-mastering network controller. Software places transmit descriptors in a word-addressed memory and programs a ring base pointer. It sets a run bit and then writes a poll-demand register. Each descriptor occupies four consecutive 32-bit words: status, control, buffer pointer and a fourth word that the engine does not use. The engine reads a descriptor and checks its ownership flag. If the device owns it, the engine reads the buffer one word at a time and sends its bytes out as a stream, least significant byte of each word first. It then writes a completion status over the status word, which hands the descriptor back to software, and moves to the next descriptor.

If the engine finds a descriptor it does not own, it suspends. It leaves suspension only on a poll-demand write. A descriptor that carries the end-of-ring flag sends the engine back to the ring base. Otherwise the engine steps four words forward. A descriptor flagged as a setup frame is consumed without sending any bytes. A descriptor with a zero byte count completes at once with its error flag set.

Top module: `txring_engine`

## Requirements
- R1: After the reset input the engine is stopped: `eng_state` reads 0, `tx_valid` is low and no memory request is made.
- R2: With the run bit (bit 13 of the register at offset 0x030) set, the engine reads the status word of the current descriptor. If bit 31 of that word is clear, the engine suspends (`eng_state` = 6) and leaves the descriptor unchanged.
- R3: A write of 1 in bit 0 to offset 0x008 while the engine is suspended makes it read the current descriptor again.
- R4: For an owned descriptor with byte count N (control bits 10:0, N > 0), exactly N bytes appear on `tx_data` with `tx_valid`. They are taken in order from the buffer at the word address in descriptor word 2, least significant byte of each word first.
- R5: `tx_sof` marks the first byte only when control bit 29 is set, and `tx_eof` marks the last byte only when control bit 30 is set.
- R6: After a normal send, the engine writes 0x00000000 to the status word. This clears ownership (bit 31) and the error flag (bit 15).
- R7: A byte count of zero sends no bytes and writes 0x00008000 to the status word.
- R8: A descriptor with control bit 27 set (setup frame) sends no bytes and writes 0x7FFFFFFF to the status word, whatever its byte count.
- R9: After a descriptor with control bit 25 set, the next fetch is at the ring base (offset 0x020, a word address). After any other descriptor, the next fetch is the current address plus 4.
- R10: Clearing the run bit brings a suspended engine to the stopped state (`eng_state` = 0). While it is stopped, poll-demand writes have no effect.
- R11: Writing 1 to bit 0 at offset 0x000 (soft reset) clears the run bit and the ring base, and returns the engine to the stopped state with its current pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| eng_state | output | 3 | Engine state: 0 stopped, 1 fetching, 3 sending, 7 writing back, 6 suspended |

## Verification
The bench uses the default address width of 10. This gives a 1024-word memory, which holds a four-slot ring at word 0x100, separate buffers, and a second descriptor at word 0 for the soft-reset case. Byte counts stay at 12 or below. That is still enough to cover single-byte frames, a partial last word and buffers that span several words. Wrap-around is exercised by running more descriptors than the ring has slots.

// File: rtl/txring_pkg.sv
package txring_pkg;
  typedef enum logic [3:0] {
    S_STOP, S_RDST, S_RDCTL, S_RDBUF, S_GOTBUF,
    S_XREQ, S_XDATA, S_XOUT, S_WB, S_SUSP
  } eng_st_t;

  localparam int OWN_BIT = 31;
  localparam int LS_BIT  = 30;
  localparam int FS_BIT  = 29;
  localparam int SET_BIT = 27;
  localparam int EOR_BIT = 25;
  localparam int RUN_BIT = 13;

  localparam logic [7:0] A_BUSMODE = 8'h00;
  localparam logic [7:0] A_POLL    = 8'h08;
  localparam logic [7:0] A_BASE    = 8'h20;
  localparam logic [7:0] A_OPMODE  = 8'h30;

  localparam logic [31:0] WB_OK    = 32'h0000_0000;
  localparam logic [31:0] WB_ERR   = 32'h0000_8000;
  localparam logic [31:0] WB_SETUP = 32'h7FFF_FFFF;

  function automatic logic [2:0] vis_state(eng_st_t s);
    case (s)
      S_STOP:                  return 3'd0;
      S_SUSP:                  return 3'd6;
      S_XREQ, S_XDATA, S_XOUT: return 3'd3;
      S_WB:                    return 3'd7;
      default:                 return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/txring_csr.sv
module txring_csr
  import txring_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [AW-1:0] base,
  output logic          run,
  output logic          poll,
  output logic          base_load,
  output logic          sreset
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      run       <= 1'b0;
      poll      <= 1'b0;
      base_load <= 1'b0;
      sreset    <= 1'b0;
    end else begin
      poll      <= 1'b0;
      base_load <= 1'b0;
      sreset    <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          A_BUSMODE: if (cfg_wdata[0]) begin
            sreset <= 1'b1;
            run    <= 1'b0;
            base   <= '0;
          end
          A_POLL:   poll <= cfg_wdata[0];
          A_BASE: begin
            base      <= cfg_wdata[AW-1:0];
            base_load <= 1'b1;
          end
          A_OPMODE: run <= cfg_wdata[RUN_BIT];
          default: ;
        endcase
      end
    end
  end

  // R11
  sreset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    sreset |-> (!run && base == '0));
endmodule

// File: rtl/txring_fsm.sv
module txring_fsm
  import txring_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic          run,
  input  logic          poll,
  input  logic          base_load,
  input  logic          sreset,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  output logic [2:0]    eng_state
);
  localparam logic [AW-1:0] DSTEP = AW'(4);

  eng_st_t       st;
  logic [AW-1:0] cur, waddr, nxt;
  logic [CW-1:0] cnt, remaining;
  logic          fs_q, ls_q, set_q, eor_q, first;
  logic [31:0]   wbuf;
  logic [1:0]    bidx;

  assign eng_state = vis_state(st);
  assign nxt = eor_q ? base : cur + DSTEP;

  always_ff @(posedge clk) begin
    if (rst || sreset) begin
      st <= S_STOP; cur <= '0; waddr <= '0; cnt <= '0; remaining <= '0;
      fs_q <= 1'b0; ls_q <= 1'b0; set_q <= 1'b0; eor_q <= 1'b0; first <= 1'b0;
      wbuf <= '0; bidx <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      tx_valid <= 1'b0; tx_data <= '0; tx_sof <= 1'b0; tx_eof <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      tx_sof   <= 1'b0;
      tx_eof   <= 1'b0;
      case (st)
        S_STOP: begin
          if (base_load) cur <= base;
          if (run) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= base_load ? base : cur;
            st       <= S_RDST;
          end
        end
        S_SUSP: begin
          if (!run) st <= S_STOP;
          else if (poll) begin
            mem_req  <= 1'b1;
            mem_addr <= cur;
            st       <= S_RDST;
          end
        end
        S_RDST: begin
          mem_addr <= cur + AW'(1);
          st       <= S_RDCTL;
        end
        S_RDCTL: begin
          if (!mem_rdata[OWN_BIT]) begin
            mem_req <= 1'b0;
            st      <= S_SUSP;
          end else begin
            mem_addr <= cur + AW'(2);
            st       <= S_RDBUF;
          end
        end
        S_RDBUF: begin
          cnt     <= mem_rdata[CW-1:0];
          fs_q    <= mem_rdata[FS_BIT];
          ls_q    <= mem_rdata[LS_BIT];
          set_q   <= mem_rdata[SET_BIT];
          eor_q   <= mem_rdata[EOR_BIT];
          mem_req <= 1'b0;
          st      <= S_GOTBUF;
        end
        S_GOTBUF: begin
          waddr     <= mem_rdata[AW-1:0];
          remaining <= cnt;
          first     <= 1'b1;
          mem_req   <= 1'b1;
          if (set_q || cnt == '0) begin
            mem_we    <= 1'b1;
            mem_addr  <= cur;
            mem_wdata <= set_q ? WB_SETUP : WB_ERR;
            st        <= S_WB;
          end else begin
            mem_addr <= mem_rdata[AW-1:0];
            st       <= S_XREQ;
          end
        end
        S_XREQ: begin
          mem_req <= 1'b0;
          st      <= S_XDATA;
        end
        S_XDATA: begin
          wbuf <= mem_rdata;
          bidx <= '0;
          st   <= S_XOUT;
        end
        S_XOUT: begin
          tx_valid  <= 1'b1;
          tx_data   <= wbuf[{bidx, 3'b000} +: 8];
          tx_sof    <= first & fs_q;
          tx_eof    <= (remaining == CW'(1)) & ls_q;
          first     <= 1'b0;
          remaining <= remaining - CW'(1);
          bidx      <= bidx + 2'd1;
          if (remaining == CW'(1)) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur;
            mem_wdata <= WB_OK;
            st        <= S_WB;
          end else if (bidx == 2'd3) begin
            waddr    <= waddr + AW'(1);
            mem_addr <= waddr + AW'(1);
            mem_req  <= 1'b1;
            st       <= S_XREQ;
          end
        end
        S_WB: begin
          mem_we <= 1'b0;
          cur    <= nxt;
          if (run) begin
            mem_req  <= 1'b1;
            mem_addr <= nxt;
            st       <= S_RDST;
          end else begin
            mem_req <= 1'b0;
            st      <= S_STOP;
          end
        end
        default: st <= S_STOP;
      endcase
    end
  end

  // R4
  byte_from_serializer_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(st == S_XOUT));
  // R6
  own_released_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);
  // R7
  zero_count_err_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WB && cnt == '0 && !set_q) |-> mem_wdata == WB_ERR);
  // R9
  ring_wrap_chk: assert property (@(posedge clk) disable iff (rst || sreset)
    (st == S_WB && eor_q) |=> cur == $past(base));
  // R2
  suspend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_SUSP) |-> !mem_req);
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  output logic [2:0]    eng_state
);
  logic [AW-1:0] base;
  logic run, poll, base_load, sreset;

  txring_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .base(base), .run(run), .poll(poll),
    .base_load(base_load), .sreset(sreset)
  );

  txring_fsm #(.AW(AW), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .base(base), .run(run), .poll(poll),
    .base_load(base_load), .sreset(sreset),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .eng_state(eng_state)
  );
endmodule

// File: tb/sim_txring_engine.sv
`timescale 1ns/1ps
module sim_txring_engine;
  localparam int AW = 10;
  localparam int RING = 'h100;
  localparam int BUFB = 'h200;
  // fields: [10:0] count, [11] first, [12] last, [13] setup, [23:16] seed
  localparam logic [31:0] VEC [6] = '{
    32'h0011_1805, 32'h0040_0808, 32'h009A_1001,
    32'h0005_1800, 32'h0020_380C, 32'h00C3_1807
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, cfg_we;
  logic [7:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_sof, tx_eof;
  logic [7:0] tx_data;
  logic [2:0] eng_state;

  txring_engine #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .eng_state(eng_state)
  );

  logic [31:0] mem [0:(1<<AW)-1];
  logic tb_we = 1'b0;
  logic [AW-1:0] tb_addr = '0;
  logic [31:0] tb_wdata = '0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= '0;
    end else if (tb_we) mem[tb_addr] <= tb_wdata;
    else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  int ncap = 0, nsof = 0, neof = 0;
  logic [7:0] cap [0:255];
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      cap[ncap[7:0]] = tx_data;
      ncap++;
      nsof += int'(tx_sof);
      neof += int'(tx_eof);
    end
  end

  int nchk = 0, nerr = 0, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic mem_put(int a, logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = AW'(a); tb_wdata = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_done(string tag, int a);
    bit ok = 1'b0;
    for (int k = 0; k < 3000 && !ok; k++) begin
      @(negedge clk);
      ok = !mem[a][31] && eng_state == 3'd6;
    end
    check_eq(tag, 32'(ok), 32'd1);
  endtask

  function automatic logic [7:0] bpat(logic [7:0] s, int j);
    return s + 8'(3 * j);
  endfunction

  task automatic fill_buf(int a, logic [7:0] s);
    for (int w = 0; w < 4; w++)
      mem_put(a + w, {bpat(s, 4*w+3), bpat(s, 4*w+2), bpat(s, 4*w+1), bpat(s, 4*w)});
  endtask

  initial begin
    int c0, s0, e0;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_eq("R1 state", 32'(eng_state), 32'd0);
    check_eq("R1 tx_valid", 32'(tx_valid), 32'd0);
    check_eq("R1 mem_req", 32'(mem_req), 32'd0);

    // R2: slot 0 not owned -> suspend, descriptor untouched
    mem_put(RING, 32'h0000_1234);
    cfg_write(8'h20, 32'(RING));
    cfg_write(8'h30, 32'h0000_2000);
    idle(12);
    check_eq("R2 suspended", 32'(eng_state), 32'd6);
    check_eq("R2 untouched", mem[RING], 32'h0000_1234);
    check_eq("R2 no bytes", 32'(ncap), 32'd0);

    for (int i = 0; i < 6; i++) begin
      int slot, d, b, cnt, nb, bad;
      logic fs, ls, su;
      logic [7:0] seed;
      logic [31:0] ctl, exps;
      string t;
      slot = i % 4; d = RING + slot*4; b = BUFB + slot*16;
      cnt = int'(VEC[i][10:0]); fs = VEC[i][11]; ls = VEC[i][12]; su = VEC[i][13];
      seed = VEC[i][23:16];
      ctl = 32'(cnt) | (32'(fs) << 29) | (32'(ls) << 30) | (32'(su) << 27)
            | ((slot == 3) ? 32'h0200_0000 : 32'h0);
      fill_buf(b, seed);
      mem_put(d+1, ctl); mem_put(d+2, 32'(b)); mem_put(d+3, 32'h0);
      mem_put(d, 32'h8000_0000);
      c0 = ncap; s0 = nsof; e0 = neof;
      cfg_write(8'h08, 32'h1);
      // R9: vector 4 is only reached if the ring wrapped to base after slot 3
      wait_done((i == 4) ? "R9 wrap" : "R3 poll", d);
      exps = su ? 32'h7FFF_FFFF : (cnt == 0) ? 32'h0000_8000 : 32'h0;
      t = su ? "R8 status" : (cnt == 0) ? "R7 status" : "R6 status";
      check_eq(t, mem[d], exps);
      nb = (su || cnt == 0) ? 0 : cnt;
      check_eq("R4 byte count", 32'(ncap - c0), 32'(nb));
      bad = 0;
      for (int j = 0; j < nb; j++)
        if (cap[8'(c0 + j)] !== bpat(seed, j)) bad++;
      check_eq("R4 byte content", 32'(bad), 32'd0);
      check_eq("R5 sof/eof", {16'(nsof - s0), 16'(neof - e0)},
               {16'((nb > 0 && fs) ? 1 : 0), 16'((nb > 0 && ls) ? 1 : 0)});
    end

    // R10: stop, then poll while stopped is ignored
    mem_put(RING+8+1, 32'h6000_0004); mem_put(RING+8+2, 32'(BUFB));
    mem_put(RING+8, 32'h8000_0000);
    c0 = ncap;
    cfg_write(8'h30, 32'h0);
    idle(6);
    check_eq("R10 stopped", 32'(eng_state), 32'd0);
    cfg_write(8'h08, 32'h1);
    idle(20);
    check_eq("R10 poll ignored state", 32'(eng_state), 32'd0);
    check_eq("R10 poll ignored own", 32'(mem[RING+8][31]), 32'd1);
    check_eq("R10 poll ignored bytes", 32'(ncap - c0), 32'd0);
    cfg_write(8'h30, 32'h0000_2000);
    wait_done("R2 restart", RING+8);
    check_eq("R4 restart bytes", 32'(ncap - c0), 32'd4);

    // R11: soft reset clears run and base
    cfg_write(8'h00, 32'h1);
    idle(20);
    check_eq("R11 stopped", 32'(eng_state), 32'd0);
    fill_buf('h300, 8'h55);
    mem_put(1, 32'h6200_0003); mem_put(2, 32'h300); mem_put(0, 32'h8000_0000);
    c0 = ncap;
    cfg_write(8'h30, 32'h0000_2000);
    wait_done("R11 base zero", 0);
    check_eq("R11 bytes", 32'(ncap - c0), 32'd3);
    check_eq("R11 first byte", 32'(cap[8'(c0)]), 32'h55);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule